// File: doc/BRIEF.md
# Vectored Interrupt Controller

This block holds the processor-side interrupt state of a 32-bit CPU with a multi-step control unit: a one-bit enable flag, a saved program counter and a 16-bit interrupt information register. When the control unit is at the first step of instruction fetch, the block decides whether to accept the pending request. On acceptance it tells the control unit to drop the normal fetch and end the step. It then supplies a vector address as the new PC, acknowledges the device for one cycle, saves the old PC and the device's cause code, and masks further requests.

The control unit also hands the block decoded instruction strobes. These cover the return from interrupt, which restores the PC and re-enables in one step, enable, disable, and copying the saved state to and from general registers. There are no priority levels: any arbitration among devices happens outside, and the block sees one request line, one 8-bit type code and one 16-bit cause code. Requests are looked at only in the fetch-start step, so a request that is raised and then dropped between fetches leaves no trace.

Top module: `irq_ctl`

## Requirements
- R1: After reset the enable flag is 0, and both the saved PC and the saved information read back as zero.
- R2: A request is accepted (`irq_take` and `iack` high) only in a cycle where `step_t0`, `ireq` and the enable flag are all 1; otherwise both stay low.
- R3: On acceptance, from the next cycle on the saved PC equals the `pc_cur` of the accepting cycle, the saved information equals that cycle's `isrc_info`, and the enable flag is 0.
- R4: In the accepting cycle `pc_wr` is 1 and `pc_wr_data` holds the 8-bit type code at bits [11:4], with bits [31:12] and [3:0] zero.
- R5: `iack` lasts exactly one cycle even when `step_t0` and `ireq` are held for several cycles.
- R6: `ireq` outside the fetch-start step is ignored: no acknowledge, and the enable flag, saved PC and saved information keep their values.
- R7: A strobe with opcode 29 (return) drives `pc_wr` with `pc_wr_data` equal to the saved PC in the same cycle, and sets the enable flag from the next cycle on.
- R8: Opcode 10 sets the enable flag and opcode 11 clears it, effective the next cycle.
- R9: Opcode 16 (save) raises `sv_we` in the same cycle, with `sv_ra_lo` equal to the saved information and `sv_rb` equal to the saved PC.
- R10: Opcode 17 (restore) loads the saved information from `ra_lo` and the saved PC from `rb_val`, effective the next cycle.
- R11: Strobes carrying any other opcode, and any strobe in the same cycle as an acceptance, change no state and drive neither `pc_wr` from the saved PC nor `sv_we`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| step_t0 | input | 1 | Control unit is at the first fetch step |
| ireq | input | 1 | Interrupt request from the external arbiter |
| isrc_info | input | 16 | Cause code from the requesting device |
| isrc_vect | input | 8 | Type code from the requesting device |
| pc_cur | input | 32 | Current program counter |
| op_stb | input | 1 | Decoded instruction strobe for this block |
| op_code | input | 5 | Opcode accompanying `op_stb` |
| ra_lo | input | 16 | Low half of register ra for restore |
| rb_val | input | 32 | Register rb for restore |
| irq_take | output | 1 | Suppress the fetch and end the step |
| iack | output | 1 | Acknowledge pulse to the device |
| ie | output | 1 | Interrupt enable flag |
| pc_wr | output | 1 | Load the PC from `pc_wr_data` |
| pc_wr_data | output | 32 | Vector address or saved PC |
| sv_we | output | 1 | Write strobe for the save instruction |
| sv_ra_lo | output | 16 | Saved information for register ra |
| sv_rb | output | 32 | Saved PC for register rb |

## Verification
The acceptance decision, the vector, the PC write and the save read-out are combinational, so they are due in the same cycle as the stimulus. The bench drives each stimulus just after a falling edge and samples these outputs one nanosecond later, before the next rising edge. The enable flag, the saved PC and the saved information change at the rising edge that ends the stimulus cycle. The bench reads them at the following falling edge, either from `ie` or through a save strobe. Each ignored-stimulus case is followed by such a read-back before any other stimulus.

// File: rtl/irq_ctl_pkg.sv
package irq_ctl_pkg;
   localparam int unsigned OPC_W = 5;

   typedef struct packed {
      logic rfi;
      logic een;
      logic edi;
      logic svi;
      logic ri;
   } irq_op_t;
endpackage

// File: rtl/irq_op_decode.sv
module irq_op_decode
   import irq_ctl_pkg::*;
#(
   parameter int unsigned OP_RFI = 29,
   parameter int unsigned OP_EEN = 10,
   parameter int unsigned OP_EDI = 11,
   parameter int unsigned OP_SVI = 16,
   parameter int unsigned OP_RI  = 17
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             op_stb,
   input  logic [OPC_W-1:0] op_code,
   input  logic             blocked,
   output irq_op_t          ops
);
   localparam logic [OPC_W-1:0] C_RFI = OPC_W'(OP_RFI);
   localparam logic [OPC_W-1:0] C_EEN = OPC_W'(OP_EEN);
   localparam logic [OPC_W-1:0] C_EDI = OPC_W'(OP_EDI);
   localparam logic [OPC_W-1:0] C_SVI = OPC_W'(OP_SVI);
   localparam logic [OPC_W-1:0] C_RI  = OPC_W'(OP_RI);

   generate
      if (OP_RFI >= (1 << OPC_W) || OP_EEN >= (1 << OPC_W) || OP_EDI >= (1 << OPC_W) ||
          OP_SVI >= (1 << OPC_W) || OP_RI >= (1 << OPC_W)) begin : g_bad_op
         $error("opcode parameter does not fit the opcode field");
      end
   endgenerate

   logic live;
   assign live = op_stb & ~blocked;

   always_comb begin
      ops     = '0;
      ops.rfi = live & (op_code == C_RFI);
      ops.een = live & (op_code == C_EEN);
      ops.edi = live & (op_code == C_EDI);
      ops.svi = live & (op_code == C_SVI);
      ops.ri  = live & (op_code == C_RI);
   end

   // R11
   op_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(ops));
   // R11
   op_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n) blocked |-> (ops == '0));
endmodule

// File: rtl/irq_entry.sv
module irq_entry #(
   parameter int unsigned XLEN    = 32,
   parameter int unsigned VEC_W   = 8,
   parameter int unsigned VEC_LSB = 4
) (
   input  logic             step_t0,
   input  logic             ireq,
   input  logic             ie,
   input  logic [VEC_W-1:0] vect,
   output logic             take,
   output logic [XLEN-1:0]  vec_addr
);
   localparam int HI_ZERO = int'(XLEN) - int'(VEC_W) - int'(VEC_LSB);

   assign take = step_t0 & ireq & ie;

   generate
      if (HI_ZERO < 0) begin : g_bad
         $error("vector field does not fit in the address width");
      end else if (HI_ZERO > 0 && VEC_LSB > 0) begin : g_mid
         assign vec_addr = {{HI_ZERO{1'b0}}, vect, {VEC_LSB{1'b0}}};
      end else if (HI_ZERO > 0) begin : g_low
         assign vec_addr = {{HI_ZERO{1'b0}}, vect};
      end else if (VEC_LSB > 0) begin : g_high
         assign vec_addr = {vect, {VEC_LSB{1'b0}}};
      end else begin : g_full
         assign vec_addr = vect;
      end
   endgenerate
endmodule

// File: rtl/irq_state_regs.sv
module irq_state_regs
   import irq_ctl_pkg::*;
#(
   parameter int unsigned XLEN   = 32,
   parameter int unsigned INFO_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              take,
   input  irq_op_t           ops,
   input  logic [XLEN-1:0]   pc_cur,
   input  logic [INFO_W-1:0] src_info,
   input  logic [INFO_W-1:0] ra_lo,
   input  logic [XLEN-1:0]   rb_val,
   output logic              ie,
   output logic [XLEN-1:0]   ipc,
   output logic [INFO_W-1:0] ii
);
   generate
      if (INFO_W > XLEN || INFO_W == 0) begin : g_bad_info
         $error("information width must be between 1 and the data width");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ie  <= 1'b0;
         ipc <= '0;
         ii  <= '0;
      end else if (take) begin
         ie  <= 1'b0;
         ipc <= pc_cur;
         ii  <= src_info;
      end else begin
         if (ops.rfi || ops.een) begin
            ie <= 1'b1;
         end else if (ops.edi) begin
            ie <= 1'b0;
         end
         if (ops.ri) begin
            ipc <= rb_val;
            ii  <= ra_lo;
         end
      end
   end

   // R3
   entry_clr_ie_chk: assert property (@(posedge clk) disable iff (!rst_n) take |=> !ie);
   // R3
   entry_save_chk: assert property (@(posedge clk) disable iff (!rst_n)
      take |=> (ipc == $past(pc_cur)) && (ii == $past(src_info)));
   // R7
   rfi_ie_chk: assert property (@(posedge clk) disable iff (!rst_n) ops.rfi |=> ie);
   // R8
   een_chk: assert property (@(posedge clk) disable iff (!rst_n) ops.een |=> ie);
   // R8
   edi_chk: assert property (@(posedge clk) disable iff (!rst_n) ops.edi |=> !ie);
   // R10
   ri_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ops.ri |=> (ipc == $past(rb_val)) && (ii == $past(ra_lo)));
   // R6
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!take && !ops.ri) |=> $stable(ipc) && $stable(ii));
endmodule

// File: rtl/irq_ctl.sv
module irq_ctl
   import irq_ctl_pkg::*;
#(
   parameter int unsigned XLEN    = 32,
   parameter int unsigned INFO_W  = 16,
   parameter int unsigned VEC_W   = 8,
   parameter int unsigned VEC_LSB = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              step_t0,
   input  logic              ireq,
   input  logic [INFO_W-1:0] isrc_info,
   input  logic [VEC_W-1:0]  isrc_vect,
   input  logic [XLEN-1:0]   pc_cur,
   input  logic              op_stb,
   input  logic [OPC_W-1:0]  op_code,
   input  logic [INFO_W-1:0] ra_lo,
   input  logic [XLEN-1:0]   rb_val,
   output logic              irq_take,
   output logic              iack,
   output logic              ie,
   output logic              pc_wr,
   output logic [XLEN-1:0]   pc_wr_data,
   output logic              sv_we,
   output logic [INFO_W-1:0] sv_ra_lo,
   output logic [XLEN-1:0]   sv_rb
);
   irq_op_t           ops;
   logic              take;
   logic [XLEN-1:0]   vec_addr;
   logic [XLEN-1:0]   ipc;
   logic [INFO_W-1:0] ii;

   irq_entry #(
      .XLEN    (XLEN),
      .VEC_W   (VEC_W),
      .VEC_LSB (VEC_LSB)
   ) entry_i (
      .step_t0  (step_t0),
      .ireq     (ireq),
      .ie       (ie),
      .vect     (isrc_vect),
      .take     (take),
      .vec_addr (vec_addr)
   );

   irq_op_decode dec_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .op_stb  (op_stb),
      .op_code (op_code),
      .blocked (take),
      .ops     (ops)
   );

   irq_state_regs #(
      .XLEN   (XLEN),
      .INFO_W (INFO_W)
   ) regs_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .take     (take),
      .ops      (ops),
      .pc_cur   (pc_cur),
      .src_info (isrc_info),
      .ra_lo    (ra_lo),
      .rb_val   (rb_val),
      .ie       (ie),
      .ipc      (ipc),
      .ii       (ii)
   );

   assign irq_take   = take;
   assign iack       = take;
   assign pc_wr      = take | ops.rfi;
   assign pc_wr_data = take ? vec_addr : ipc;
   assign sv_we      = ops.svi;
   assign sv_ra_lo   = ii;
   assign sv_rb      = ipc;

   // R5
   iack_single_chk: assert property (@(posedge clk) disable iff (!rst_n) iack |=> !iack);
   // R2
   ack_needs_t0_chk: assert property (@(posedge clk) disable iff (!rst_n) !step_t0 |-> !iack);
   // R4
   vec_form_chk: assert property (@(posedge clk) disable iff (!rst_n)
      iack |-> pc_wr && (pc_wr_data == (XLEN'(isrc_vect) << VEC_LSB)));
   // R7
   rfi_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pc_wr && !iack) |-> (pc_wr_data == sv_rb));
endmodule

// File: tb/irq_ctl_tb_top.sv
`timescale 1ns/1ps
module irq_ctl_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        step_t0 = 1'b0;
   logic        ireq = 1'b0;
   logic [15:0] isrc_info = '0;
   logic [7:0]  isrc_vect = '0;
   logic [31:0] pc_cur = '0;
   logic        op_stb = 1'b0;
   logic [4:0]  op_code = '0;
   logic [15:0] ra_lo = '0;
   logic [31:0] rb_val = '0;
   logic        irq_take, iack, ie, pc_wr, sv_we;
   logic [31:0] pc_wr_data, sv_rb;
   logic [15:0] sv_ra_lo;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   irq_ctl dut_i (
      .clk(clk), .rst_n(rst_n), .step_t0(step_t0), .ireq(ireq),
      .isrc_info(isrc_info), .isrc_vect(isrc_vect), .pc_cur(pc_cur),
      .op_stb(op_stb), .op_code(op_code), .ra_lo(ra_lo), .rb_val(rb_val),
      .irq_take(irq_take), .iack(iack), .ie(ie), .pc_wr(pc_wr),
      .pc_wr_data(pc_wr_data), .sv_we(sv_we), .sv_ra_lo(sv_ra_lo), .sv_rb(sv_rb)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic idle();
      step_t0 = 0; ireq = 0; op_stb = 0; op_code = '0;
   endtask

   task automatic do_op(input logic [4:0] code);
      @(negedge clk);
      op_stb = 1; op_code = code;
      @(negedge clk);
      idle();
   endtask

   // save strobe: read saved state through the normal interface (R9)
   task automatic readback(input string req, input logic [31:0] exp_ipc, input logic [15:0] exp_ii);
      @(negedge clk);
      op_stb = 1; op_code = 5'd16;
      #1;
      chk({req, " R9 sv_we"}, 32'(sv_we), 32'd1);
      chk({req, " saved pc"}, sv_rb, exp_ipc);
      chk({req, " saved info"}, 32'(sv_ra_lo), 32'(exp_ii));
      @(negedge clk);
      idle();
   endtask

   task automatic t_reset();
      #1;
      chk("R1 ie", 32'(ie), 32'd0);
      readback("R1", 32'd0, 16'd0);
   endtask

   task automatic t_enable();
      do_op(5'd10);
      chk("R8 een", 32'(ie), 32'd1);
      do_op(5'd11);
      chk("R8 edi", 32'(ie), 32'd0);
   endtask

   task automatic t_masked();
      @(negedge clk);
      step_t0 = 1; ireq = 1; pc_cur = 32'h0000_2000;
      #1;
      chk("R2 masked iack", 32'(iack), 32'd0);
      chk("R2 masked take", 32'(irq_take), 32'd0);
      @(negedge clk);
      idle();
   endtask

   task automatic t_take(input logic [31:0] pc, input logic [15:0] info, input logic [7:0] vec);
      do_op(5'd10);
      @(negedge clk);
      step_t0 = 1; ireq = 1; pc_cur = pc; isrc_info = info; isrc_vect = vec;
      #1;
      chk("R2 iack", 32'(iack), 32'd1);
      chk("R2 take", 32'(irq_take), 32'd1);
      chk("R4 pc_wr", 32'(pc_wr), 32'd1);
      chk("R4 vector", pc_wr_data, {20'd0, vec, 4'd0});
      @(negedge clk);
      idle();
      chk("R3 ie cleared", 32'(ie), 32'd0);
      readback("R3", pc, info);
   endtask

   task automatic t_no_t0();
      do_op(5'd10);
      @(negedge clk);
      ireq = 1; pc_cur = 32'h5555_0000; isrc_info = 16'h1111;
      for (int i = 0; i < 3; i++) begin
         #1;
         chk("R6 iack without t0", 32'(iack), 32'd0);
         @(negedge clk);
      end
      ireq = 0;
      step_t0 = 1;
      #1;
      chk("R6 dropped request", 32'(iack), 32'd0);
      @(negedge clk);
      idle();
      chk("R6 ie kept", 32'(ie), 32'd1);
      readback("R6", 32'h0000_1234, 16'h5A5A);
   endtask

   task automatic t_pulse();
      @(negedge clk);
      step_t0 = 1; ireq = 1; pc_cur = 32'h0000_3000; isrc_info = 16'h7777; isrc_vect = 8'h3C;
      #1;
      chk("R5 first cycle", 32'(iack), 32'd1);
      @(negedge clk);
      #1;
      chk("R5 second cycle", 32'(iack), 32'd0);
      @(negedge clk);
      idle();
      readback("R5", 32'h0000_3000, 16'h7777);
   endtask

   task automatic t_rfi();
      @(negedge clk);
      op_stb = 1; op_code = 5'd29;
      #1;
      chk("R7 pc_wr", 32'(pc_wr), 32'd1);
      chk("R7 pc value", pc_wr_data, 32'h0000_3000);
      @(negedge clk);
      idle();
      chk("R7 ie set", 32'(ie), 32'd1);
   endtask

   task automatic t_ri();
      @(negedge clk);
      op_stb = 1; op_code = 5'd17; ra_lo = 16'h1234; rb_val = 32'hCAFE_F00D;
      @(negedge clk);
      idle();
      readback("R10", 32'hCAFE_F00D, 16'h1234);
   endtask

   task automatic t_ignore();
      // unknown opcode
      @(negedge clk);
      op_stb = 1; op_code = 5'd5; ra_lo = 16'hFFFF; rb_val = 32'hFFFF_FFFF;
      #1;
      chk("R11 unknown no pc_wr", 32'(pc_wr), 32'd0);
      chk("R11 unknown no sv_we", 32'(sv_we), 32'd0);
      @(negedge clk);
      idle();
      chk("R11 unknown ie", 32'(ie), 32'd1);
      readback("R11 unknown", 32'hCAFE_F00D, 16'h1234);
      // restore strobe concurrent with acceptance: acceptance wins
      @(negedge clk);
      step_t0 = 1; ireq = 1; pc_cur = 32'h0000_4444; isrc_info = 16'h0F0F; isrc_vect = 8'h01;
      op_stb = 1; op_code = 5'd17;
      #1;
      chk("R11 vector wins", pc_wr_data, 32'h0000_0010);
      @(negedge clk);
      idle();
      readback("R11 concurrent", 32'h0000_4444, 16'h0F0F);
      // enable concurrent with acceptance: ignored
      do_op(5'd10);
      @(negedge clk);
      step_t0 = 1; ireq = 1; pc_cur = 32'h0000_6000; isrc_info = 16'h0001; isrc_vect = 8'h02;
      op_stb = 1; op_code = 5'd10;
      @(negedge clk);
      idle();
      chk("R11 een during take", 32'(ie), 32'd0);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual running expected finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      idle();
      repeat (3) @(negedge clk);
      rst_n = 1;
      t_reset();
      t_enable();
      t_masked();
      t_take(32'h0000_1000, 16'hBEEF, 8'hA5);
      t_take(32'hFFFF_FFFC, 16'hFFFF, 8'hFF);
      // set known state for the ignored-request test
      @(negedge clk);
      op_stb = 1; op_code = 5'd17; ra_lo = 16'h5A5A; rb_val = 32'h0000_1234;
      @(negedge clk);
      idle();
      t_no_t0();
      t_take(32'h0000_0004, 16'h0000, 8'h00);
      do_op(5'd10);
      t_pulse();
      t_rfi();
      t_ri();
      t_ignore();
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule